// File: doc/BRIEF.md
# GPIO Controller with Level Interrupts

This block is a general-purpose I/O port of up to 32 pins with level-sensitive interrupt sources. Each pin can be an output, driven from a data register, or an input, whose level is brought through a two-flop synchroniser before anything uses it. Every pin is also an interrupt source. The source fires while the synchronised pin level matches a per-pin polarity bit, and it latches into a status bit. Software acknowledges a status bit by writing zero to its position.

A second register bank acts as a small interrupt controller. It holds a mask register that resets with every source masked, and a read-only pending view. The block drives one combined interrupt line toward the host, which is the OR of all unmasked status bits.

Software reaches both banks over a plain single-cycle 32-bit register bus. A bank-select input chooses the bank, a byte address chooses the register, and read data is registered one cycle after the request.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset the direction and output-data registers are all zero, the polarity register and the mask register are all ones, the status register is zero, and `irq_out` is 0.
- R2: In the port bank (`bus_bank`=0) the direction register is at byte offset 0x00. Bit i set to 1 drives `pin_oe[i]`=1 and `pin_out[i]` from data bit i. Bit i at 0 makes the pin an input. The register reads back as written.
- R3: The data register is in the port bank at byte offset 0x04. A read returns the stored data bit for output pins and the synchronised pin level for input pins. A change on `pin_in` is first visible to a read whose request is sampled on the third rising edge after the change.
- R4: The polarity register is in the port bank at byte offset 0x08. For each pin, 1 selects active-high and 0 selects active-low. Status bit i sets on the third rising edge after the pin reaches its active level.
- R5: A set status bit stays set after the pin leaves its active level, until it is acknowledged.
- R6: A write to the status register (port bank, byte offset 0x0C) clears each bit written as 0 and leaves each bit written as 1 unchanged. A bit whose pin is still active sets again on the next rising edge.
- R7: The mask register is in the controller bank (`bus_bank`=1) at byte offset 0x08. A mask bit of 1 keeps that source from `irq_out` and from pending, but its status bit still sets.
- R8: The pending register is in the controller bank at byte offset 0x00. It reads as status AND NOT mask. Writes to it change nothing.
- R9: `irq_out` is the OR of all pending bits. It follows a change of status or mask with no extra cycle of delay.
- R10: A read request with `bus_en`=1 and `bus_we`=0 loads `bus_rdata` on the next rising edge. Unmapped offsets (controller bank 0x04 and 0x0C) and byte addresses with bits [1:0] not zero read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_bank | input | 1 | 0 = port bank, 1 = interrupt-controller bank |
| bus_addr | input | 4 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables |
| irq_out | output | 1 | Combined level interrupt toward the host |

## Verification
A pin change crosses two synchroniser flops, so the status bit for that pin sets on the third rising edge after the change. `irq_out` follows on that same edge. The bench drives the pin at a falling edge and samples `irq_out` at the second and third falling edges after it, expecting 0 and then 1. Register writes take effect on the rising edge inside the write cycle, and read data appears on the rising edge inside the read cycle. Every check therefore samples at the falling edge that closes the access. An acknowledge of a still-active pin is followed at once by a read, which must see the bit cleared, and then by a second read, which must see it set again.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int WORD_LSB = 2;

    typedef enum logic {
        BANK_PORT = 1'b0,
        BANK_INTC = 1'b1
    } bank_e;

    typedef logic [ADDR_W-WORD_LSB-1:0] word_t;

    // word index = byte offset / 4; software-visible layout
    localparam word_t PORT_DIR   = 2'd0;
    localparam word_t PORT_DATA  = 2'd1;
    localparam word_t PORT_POL   = 2'd2;
    localparam word_t PORT_STAT  = 2'd3;
    localparam word_t INTC_PEND  = 2'd0;
    localparam word_t INTC_MASK  = 2'd2;

    typedef struct packed {
        logic dir;
        logic dout;
        logic pol;
        logic stat;
        logic mask;
    } wr_sel_t;

    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_DIR,
        SRC_DATA,
        SRC_POL,
        SRC_STAT,
        SRC_PEND,
        SRC_MASK
    } rd_src_e;

    function automatic wr_sel_t decode_wr(input logic strobe, input bank_e bank,
                                          input word_t word);
        wr_sel_t s;
        s = '0;
        if (strobe) begin
            if (bank == BANK_PORT) begin
                s.dir  = (word == PORT_DIR);
                s.dout = (word == PORT_DATA);
                s.pol  = (word == PORT_POL);
                s.stat = (word == PORT_STAT);
            end else begin
                s.mask = (word == INTC_MASK);
            end
        end
        return s;
    endfunction

    function automatic rd_src_e decode_rd(input bank_e bank, input word_t word);
        rd_src_e r;
        r = SRC_ZERO;
        if (bank == BANK_PORT) begin
            case (word)
                PORT_DIR:  r = SRC_DIR;
                PORT_DATA: r = SRC_DATA;
                PORT_POL:  r = SRC_POL;
                default:   r = SRC_STAT;
            endcase
        end else begin
            if (word == INTC_PEND)      r = SRC_PEND;
            else if (word == INTC_MASK) r = SRC_MASK;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_sel_t          wsel,
    input  logic [NPINS-1:0] wval,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] pol_q,
    output logic [NPINS-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '1;
            mask_q <= '1;
        end else begin
            if (wsel.dir)  dir_q  <= wval;
            if (wsel.dout) dout_q <= wval;
            if (wsel.pol)  pol_q  <= wval;
            if (wsel.mask) mask_q <= wval;
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] status_q
);
    logic [NPINS-1:0] hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        // level match: high when polarity 1, low when polarity 0
        assign hit[i] = ~(pin_sync[i] ^ pol[i]);

        always_ff @(posedge clk) begin
            if (rst)
                status_q[i] <= 1'b0;
            else
                // acknowledge wins in its own cycle; a live level re-sets next cycle
                status_q[i] <= (status_q[i] | hit[i]) & ~clr[i];
        end
    end
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_bank,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_out
);
    bank_e            bank;
    word_t            word;
    logic             aligned;
    wr_sel_t          wsel;
    rd_src_e          rsrc;
    logic [NPINS-1:0] wval;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] dout_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] stat_clr;
    logic [NPINS-1:0] pin_view;
    logic [NPINS-1:0] pending;
    logic [NPINS-1:0] rd_sel;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    assign bank    = bank_e'(bus_bank);
    assign word    = bus_addr[ADDR_W-1:WORD_LSB];
    assign aligned = (bus_addr[WORD_LSB-1:0] == '0);
    assign wsel    = decode_wr(bus_en && bus_we && aligned, bank, word);
    assign rsrc    = aligned ? decode_rd(bank, word) : SRC_ZERO;
    assign wval    = bus_wdata[NPINS-1:0];

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (sync_q)
    );

    gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wsel   (wsel),
        .wval   (wval),
        .dir_q  (dir_q),
        .dout_q (dout_q),
        .pol_q  (pol_q),
        .mask_q (mask_q)
    );

    assign stat_clr = wsel.stat ? ~wval : '0;

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (sync_q),
        .pol      (pol_q),
        .clr      (stat_clr),
        .status_q (status_q)
    );

    assign pin_view = (dir_q & dout_q) | (~dir_q & sync_q);
    assign pending  = status_q & ~mask_q;
    assign irq_out  = |pending;
    assign pin_out  = dout_q;
    assign pin_oe   = dir_q;

    always_comb begin
        case (rsrc)
            SRC_DIR:  rd_sel = dir_q;
            SRC_DATA: rd_sel = pin_view;
            SRC_POL:  rd_sel = pol_q;
            SRC_STAT: rd_sel = status_q;
            SRC_PEND: rd_sel = pending;
            SRC_MASK: rd_sel = mask_q;
            default:  rd_sel = '0;
        endcase
        rd_next = '0;
        rd_next[NPINS-1:0] = rd_sel;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_en && !bus_we)
            rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;
endmodule

module gpio_lvl_irq_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] sync_q,
    input logic [NPINS-1:0] pol_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] stat_clr,
    input logic             irq_out
);
    // R1: every source masked on the first cycle out of reset
    a_r1_mask_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == {NPINS{1'b1}}));

    // R4: a matching level not being acknowledged sets status one edge later
    a_r4_level_sets: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((status_q & $past(~(sync_q ^ pol_q) & ~stat_clr))
                         == $past(~(sync_q ^ pol_q) & ~stat_clr)));

    // R5: a set bit survives unless acknowledged
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((status_q & $past(status_q & ~stat_clr))
                         == $past(status_q & ~stat_clr)));

    // R6: acknowledged bits read zero on the following cycle
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((status_q & $past(stat_clr)) == '0));

    // R9: combined output follows unmasked status
    a_r9_irq_combine: assert property (@(posedge clk) disable iff (rst)
        irq_out == (|(status_q & ~mask_q)));
endmodule

bind gpio_lvl_irq gpio_lvl_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_q   (sync_q),
    .pol_q    (pol_q),
    .mask_q   (mask_q),
    .status_q (status_q),
    .stat_clr (stat_clr),
    .irq_out  (irq_out)
);

// File: tb/test_gpio_lvl_irq.sv
module test_gpio_lvl_irq;
    localparam int NP = 8;
    localparam logic [31:0] ALL = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_bank = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_lvl_irq #(.NPINS(NP)) i_gpio_lvl_irq (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_bank(bus_bank),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic bank, input logic [3:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_bank = bank; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic bank, input logic [3:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_bank = bank; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] bit_i;
        logic [31:0] idle_lvl;
        idle(3);
        rst = 0;
        idle(1);

        // R1 reset state
        chk("R1 irq_out", {31'b0, irq_out}, 0);
        chk("R1 pin_oe", {24'b0, pin_oe}, 0);
        rd(0, 4'h0, v); chk("R1 dir", v, 0);
        rd(0, 4'h4, v); chk("R1 data", v, 0);
        rd(0, 4'h8, v); chk("R1 polarity", v, ALL);
        rd(0, 4'hC, v); chk("R1 status", v, 0);
        rd(1, 4'h8, v); chk("R1 mask", v, ALL);
        rd(1, 4'h0, v); chk("R1 pending", v, 0);

        // R2 / R3 direction and mixed readback
        wr(0, 4'h0, 32'hA5);
        wr(0, 4'h4, 32'h3C);
        pin_in = 8'h0F;
        idle(3);
        chk("R2 pin_oe", {24'b0, pin_oe}, 32'hA5);
        chk("R2 pin_out", {24'b0, pin_out}, 32'h3C);
        rd(0, 4'h0, v); chk("R2 dir readback", v, 32'hA5);
        rd(0, 4'h4, v); chk("R3 mixed data", v, (32'h3C & 32'hA5) | (32'h0F & ~32'hA5 & ALL));

        // R3 synchroniser latency on inputs
        wr(0, 4'h0, 0);
        idle(1);
        pin_in = 8'h50;
        rd(0, 4'h4, v); chk("R3 first read old", v, 32'h0F);
        rd(0, 4'h4, v); chk("R3 second read old", v, 32'h0F);
        rd(0, 4'h4, v); chk("R3 third read new", v, 32'h50);

        // R4 timing: polarity high, unmasked, pin 3
        pin_in = 0;
        idle(3);
        wr(0, 4'hC, 0);
        wr(1, 4'h8, 0);
        chk("R4 idle irq", {31'b0, irq_out}, 0);
        pin_in = 8'h08;
        idle(2); chk("R4 irq before third edge", {31'b0, irq_out}, 0);
        idle(1); chk("R4 irq on third edge", {31'b0, irq_out}, 1);
        pin_in = 0;
        idle(3);
        wr(0, 4'hC, 0);

        // sweep every pin under both polarities
        for (int p = 0; p < 2; p++) begin
            idle_lvl = (p == 1) ? 32'h00 : ALL;
            pin_in = idle_lvl[NP-1:0];
            idle(3);
            wr(0, 4'h8, (p == 1) ? ALL : 32'h0);
            idle(2);
            wr(0, 4'hC, 0);
            rd(0, 4'hC, v); chk("R4 quiet after polarity", v, 0);
            for (int i = 0; i < NP; i++) begin
                bit_i = 32'(1) << i;
                wr(1, 4'h8, bit_i);
                pin_in = idle_lvl[NP-1:0] ^ bit_i[NP-1:0];
                idle(4);
                chk("R7 masked irq", {31'b0, irq_out}, 0);
                rd(0, 4'hC, v); chk("R4 status set", v, bit_i);
                rd(1, 4'h0, v); chk("R8 pending masked", v, 0);
                wr(1, 4'h8, 0);
                chk("R9 irq after unmask", {31'b0, irq_out}, 1);
                rd(1, 4'h0, v); chk("R8 pending", v, bit_i);
                pin_in = idle_lvl[NP-1:0];
                idle(4);
                rd(0, 4'hC, v); chk("R5 sticky status", v, bit_i);
                chk("R5 sticky irq", {31'b0, irq_out}, 1);
                wr(0, 4'hC, ~bit_i);
                chk("R6 irq after ack", {31'b0, irq_out}, 0);
                rd(0, 4'hC, v); chk("R6 status after ack", v, 0);
            end
        end

        // R6: write-one keeps, write-zero clears, live level re-sets
        wr(0, 4'h8, ALL);
        pin_in = 8'h03;
        idle(4);
        rd(0, 4'hC, v); chk("R6 both set", v, 32'h03);
        wr(0, 4'hC, 32'hFFFF_FFFE);
        rd(0, 4'hC, v); chk("R6 cleared bit0 kept bit1", v, 32'h02);
        rd(0, 4'hC, v); chk("R6 bit0 re-set", v, 32'h03);
        pin_in = 0;
        idle(3);
        wr(0, 4'hC, 0);
        rd(0, 4'hC, v); chk("R6 all cleared", v, 0);

        // R8: pending ignores writes
        pin_in = 8'h04;
        idle(4);
        wr(1, 4'h0, 0);
        rd(1, 4'h0, v); chk("R8 pending after write", v, 32'h04);
        rd(1, 4'h8, v); chk("R8 mask untouched", v, 0);

        // R10 unmapped and unaligned
        rd(1, 4'h4, v); chk("R10 intc 0x04 reads 0", v, 0);
        rd(1, 4'hC, v); chk("R10 intc 0x0C reads 0", v, 0);
        wr(1, 4'h4, ALL);
        wr(1, 4'h9, ALL);
        rd(1, 4'h8, v); chk("R10 mask unchanged", v, 0);
        chk("R10 irq still set", {31'b0, irq_out}, 1);
        rd(0, 4'h5, v); chk("R10 unaligned read 0", v, 0);
        wr(0, 4'h1, ALL);
        rd(0, 4'h0, v); chk("R10 unaligned write ignored", v, 0);

        done = 1;
        summary();
    end
endmodule